// File: doc/BRIEF.md
# USB Port Clock Source, Divider and Gate

This block derives the clock for a USB device port. It picks one of two PLL clocks, divides it by a whole number from 1 to 16, and lets the result reach the port only while an enable flag is set. Software controls that flag through two write strobes sharing one data bit. One strobe sets the flag and the other clears it. The flag is returned on a read-only status output.

The enable flag lives in the register clock domain. It only turns on while the PLL lock input is high, so the port clock cannot start from an unstable PLL. The flag crosses into the selected PLL clock domain through a two-stage synchronizer. The divider changes its ratio or gating only when its count wraps, so every output period is whole.

Top module: `usbck_top`

## Requirements
- R1: While reset is asserted and after its release with no write, `usb_en_stat` is 0 and `usb_clk` stays low.
- R2: A cycle with `set_we`=1, `wr_bit`=1, `pll_lock`=1 and no effective clear makes `usb_en_stat` 1 after that `clk` rising edge.
- R3: A set write while `pll_lock` is 0 is ignored: `usb_en_stat` stays 0.
- R4: A cycle with `clr_we`=1 and `wr_bit`=1 makes `usb_en_stat` 0 after that edge, even when `set_we` is 1 in the same cycle.
- R5: A strobe with `wr_bit`=0, or no strobe at all, leaves `usb_en_stat` unchanged.
- R6: `src_sel`=0 clocks the path from `pll_a_clk` and `src_sel`=1 clocks it from `pll_b_clk`.
- R7: `div_field` holds N-1. The `usb_clk` period is N cycles of the selected source, so 0 gives divide by 1 and 15 gives divide by 16.
- R8: For N of 2 or more, `usb_clk` is high for floor(N/2) source cycles of each period and low for the rest. For N=1, `usb_clk` follows the source clock.
- R9: Once the enable has been cleared and the current period has ended, `usb_clk` stays low.
- R10: A new `div_field` value is taken only when the count wraps. The period that is running when the field changes completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock for the enable flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_a_clk | input | 1 | First PLL clock source |
| pll_b_clk | input | 1 | Second PLL clock source |
| src_sel | input | 1 | Source choice: 0 first PLL, 1 second PLL |
| div_field | input | 4 | Divide ratio minus one |
| set_we | input | 1 | Write strobe of the set register |
| clr_we | input | 1 | Write strobe of the clear register |
| wr_bit | input | 1 | Data bit written with either strobe |
| pll_lock | input | 1 | Lock flag of the selected PLL |
| usb_clk | output | 1 | Divided, gated USB port clock |
| usb_en_stat | output | 1 | Current state of the enable flag |

## Verification
A set write and a clear write can land on the same `clk` edge. The bench drives both strobes with `wr_bit`=1 in one cycle and expects the flag to read 0 afterwards. It then counts `usb_clk` rising edges over a window to confirm the port clock has stopped. A divide-field change can also fall in the middle of a running period. The bench writes it just after a rising edge of `usb_clk` and times that period and the next one: the first keeps the old length and the second has the new length.

// File: rtl/usbck_pkg.sv
package usbck_pkg;
  localparam int DIV_W       = 4;
  localparam int SYNC_STAGES = 2;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/usbck_sync.sv
module usbck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/usbck_en_reg.sv
module usbck_en_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_we,
  input  logic clr_we,
  input  logic wr_bit,
  input  logic pll_lock,
  output logic en_q
);
  logic en_d;
  logic do_set;
  logic do_clr;

  assign do_clr = clr_we & wr_bit;
  assign do_set = set_we & wr_bit & pll_lock;

  // clear outranks set when both land together
  always_comb begin
    en_d = en_q;
    if (do_clr)      en_d = 1'b0;
    else if (do_set) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/usbck_div.sv
module usbck_div
  import usbck_pkg::*;
(
  input  logic src_clk,
  input  logic src_rst_n,
  input  div_t div_field,
  input  logic en_req,
  output logic usb_clk,
  output div_t cnt_o,
  output div_t ratio_o
);
  localparam int HW = DIV_W + 1;

  div_t          cnt_q, cnt_d;
  div_t          ratio_q, ratio_d;
  logic          en_live_q, en_live_d;
  logic          hi_q, hi_d;
  logic          en_neg_q;
  logic          term;
  logic [HW-1:0] half;

  assign term = (cnt_q == ratio_q);

  // ratio and enable are refreshed only at the wrap point
  always_comb begin
    if (term) begin
      cnt_d     = '0;
      ratio_d   = div_field;
      en_live_d = en_req;
    end else begin
      cnt_d     = cnt_q + div_t'(1);
      ratio_d   = ratio_q;
      en_live_d = en_live_q;
    end
    half = ({1'b0, ratio_d} + HW'(1)) >> 1;
    hi_d = en_live_d && ({1'b0, cnt_d} < half);
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      cnt_q     <= '0;
      ratio_q   <= '0;
      en_live_q <= 1'b0;
      hi_q      <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      ratio_q   <= ratio_d;
      en_live_q <= en_live_d;
      hi_q      <= hi_d;
    end
  end

  // gate for the divide-by-one path, changed while the source is low
  always_ff @(negedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) en_neg_q <= 1'b0;
    else            en_neg_q <= en_live_q;
  end

  assign usb_clk = (ratio_q == '0) ? (src_clk & en_neg_q) : hi_q;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/usbck_top.sv
module usbck_top
  import usbck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_a_clk,
  input  logic             pll_b_clk,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_field,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             wr_bit,
  input  logic             pll_lock,
  output logic             usb_clk,
  output logic             usb_en_stat
);
  logic src_clk;
  logic src_rst_n;
  logic en_q;
  logic en_src;
  div_t cnt_w;
  div_t ratio_w;

  assign src_clk = src_sel ? pll_b_clk : pll_a_clk;

  usbck_en_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .wr_bit   (wr_bit),
    .pll_lock (pll_lock),
    .en_q     (en_q)
  );

  usbck_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (src_rst_n)
  );

  usbck_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (en_q),
    .q     (en_src)
  );

  usbck_div u_div (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .div_field (div_field),
    .en_req    (en_src),
    .usb_clk   (usb_clk),
    .cnt_o     (cnt_w),
    .ratio_o   (ratio_w)
  );

  assign usb_en_stat = en_q;
endmodule

// File: rtl/usbck_chk.sv
module usbck_chk
  import usbck_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic src_clk,
  input logic src_rst_n,
  input logic set_we,
  input logic clr_we,
  input logic wr_bit,
  input logic pll_lock,
  input logic usb_en_stat,
  input div_t cnt_w,
  input div_t ratio_w
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && wr_bit && pll_lock && !clr_we) |=> usb_en_stat);

  p_nolock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!usb_en_stat && !pll_lock) |=> !usb_en_stat);

  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wr_bit) |=> !usb_en_stat);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_en_stat && !(clr_we && wr_bit)) |=> usb_en_stat);

  p_cnt_range_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    cnt_w <= ratio_w);

  p_ratio_at_wrap_r10: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (ratio_w != $past(ratio_w)) |-> ($past(cnt_w) == $past(ratio_w)));
endmodule

bind usbck_top usbck_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_clk     (src_clk),
  .src_rst_n   (src_rst_n),
  .set_we      (set_we),
  .clr_we      (clr_we),
  .wr_bit      (wr_bit),
  .pll_lock    (pll_lock),
  .usb_en_stat (usb_en_stat),
  .cnt_w       (cnt_w),
  .ratio_w     (ratio_w)
);

// File: tb/tb_usbck_top.sv
`timescale 1ns/100ps
module tb_usbck_top;
  logic       clk, rst_n, pll_a_clk, pll_b_clk, src_sel;
  logic [3:0] div_field;
  logic       set_we, clr_we, wr_bit, pll_lock;
  logic       usb_clk, usb_en_stat;

  int total = 0;
  int bad   = 0;
  int usb_edges = 0;

  usbck_top dut (
    .clk(clk), .rst_n(rst_n), .pll_a_clk(pll_a_clk), .pll_b_clk(pll_b_clk),
    .src_sel(src_sel), .div_field(div_field), .set_we(set_we), .clr_we(clr_we),
    .wr_bit(wr_bit), .pll_lock(pll_lock), .usb_clk(usb_clk), .usb_en_stat(usb_en_stat)
  );

  initial begin clk = 0;       forever #10 clk = ~clk; end
  initial begin pll_a_clk = 0; forever #5  pll_a_clk = ~pll_a_clk; end
  initial begin pll_b_clk = 0; forever #7  pll_b_clk = ~pll_b_clk; end

  always @(posedge usb_clk) usb_edges++;

  // vectors: source, field, period and high time in tenths of ns
  localparam int NV = 8;
  localparam bit VSEL [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};
  localparam int VDIV [NV] = '{0, 1, 2, 15, 4, 7, 8, 0};
  localparam int VPER [NV] = '{100, 200, 300, 1600, 700, 1120, 900, 140};
  localparam int VHI  [NV] = '{50, 100, 100, 800, 280, 560, 400, 70};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit s, input bit c, input bit b);
    @(negedge clk);
    set_we = s; clr_we = c; wr_bit = b;
    @(negedge clk);
    set_we = 0; clr_we = 0; wr_bit = 0;
  endtask

  task automatic measure(input int skip, output int per, output int hi);
    realtime t0, t1, t2;
    repeat (skip) @(posedge usb_clk);
    @(posedge usb_clk); t0 = $realtime;
    @(negedge usb_clk); t1 = $realtime;
    @(posedge usb_clk); t2 = $realtime;
    per = int'((t2 - t0) * 10.0);
    hi  = int'((t1 - t0) * 10.0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, e0;
    realtime ta, tb;
    rst_n = 0; src_sel = 0; div_field = 0;
    set_we = 0; clr_we = 0; wr_bit = 0; pll_lock = 0;
    #55;
    chk(usb_en_stat == 0, "R1 stat in reset", usb_en_stat, 0);
    chk(usb_clk == 0, "R1 clk in reset", usb_clk, 0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk(usb_en_stat == 0, "R1 stat after reset", usb_en_stat, 0);

    wr(1, 0, 1);
    chk(usb_en_stat == 0, "R3 set without lock", usb_en_stat, 0);
    e0 = usb_edges;
    repeat (20) @(negedge clk);
    chk(usb_edges == e0, "R9 no clock while off", usb_edges - e0, 0);

    pll_lock = 1;
    wr(1, 0, 0);
    chk(usb_en_stat == 0, "R5 set with bit 0", usb_en_stat, 0);
    wr(1, 0, 1);
    chk(usb_en_stat == 1, "R2 set with lock", usb_en_stat, 1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_sel = VSEL[i]; div_field = 4'(VDIV[i]);
      measure(3, per, hi);
      chk(per == VPER[i], VSEL[i] ? "R6/R7 period src b" : "R6/R7 period src a", per, VPER[i]);
      chk(hi == VHI[i], "R8 high time", hi, VHI[i]);
    end

    wr(0, 1, 0);
    chk(usb_en_stat == 1, "R5 clear with bit 0", usb_en_stat, 1);

    // R10: change the field in the middle of a long period
    @(negedge clk); src_sel = 0; div_field = 4'd15;
    measure(3, per, hi);
    @(posedge usb_clk); ta = $realtime;
    #1 div_field = 4'd2;
    @(posedge usb_clk); tb = $realtime;
    per = int'((tb - ta) * 10.0);
    chk(per == 1600, "R10 running period keeps old ratio", per, 1600);
    measure(0, per, hi);
    chk(per == 300, "R10 new ratio after wrap", per, 300);

    wr(1, 1, 1);
    chk(usb_en_stat == 0, "R4 clear beats set", usb_en_stat, 1'b0);
    repeat (20) @(negedge clk);
    e0 = usb_edges;
    repeat (40) @(negedge clk);
    chk(usb_edges == e0, "R9 stopped after clear", usb_edges - e0, 0);
    chk(usb_clk == 0, "R9 held low", usb_clk, 0);

    wr(1, 0, 1);
    chk(usb_en_stat == 1, "R2 set again", usb_en_stat, 1);
    wr(0, 1, 1);
    chk(usb_en_stat == 0, "R4 plain clear", usb_en_stat, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule